// File: doc/BRIEF.md
# Key-protected independent watchdog timer

This block is a watchdog counter for a system that must recover on its own when software stops making progress. It counts down from a programmed reload value, paced by a slow, free-running tick that has been divided through a selectable prescaler. If software does not refresh the counter before it runs out, the block raises a one-cycle reset request for the chip's reset logic.

Software reaches the block through a plain write port and a combinational read port. There are four word addresses: key, prescaler, reload and status. Magic values written to the key address start the watchdog, refresh it, and unlock the two configuration registers. Once the watchdog is started, no write can stop it; only a reset of the block does.

A configuration write is not applied at once. It is held as pending, a hardware-owned busy flag is raised, and the new value is applied on the next slow tick. The slow clock is modelled as a tick-enable input inside the single block clock domain.

Top module: `kwdt_top`

## Requirements
- R1: After reset the prescaler reads 0, the reload reads 0xFFF, the status reads 0, the reset request is low and the watchdog is stopped.
- R2: Writing 0x5555 to the key address (0) unlocks the prescaler (address 1) and reload (address 2). While locked, writes to those addresses are ignored: the stored value and the busy flag do not change. Any other value written to the key address, including the refresh and start keys, locks them again.
- R3: An accepted configuration write raises its status bit (bit 0 for the prescaler, bit 1 for the reload, read at address 3). On the next tick the new value becomes readable and the bit clears. A write to a register whose bit is set is ignored.
- R4: Prescaler code c in bits 2:0 divides the tick by 4·2^c for c = 0..5. Codes 6 and 7 both divide by 256.
- R5: Writing 0xAAAA to the key address loads the counter from the reload register and restarts the prescaler phase. Refreshes that come more often than the timeout keep the reset request low.
- R6: Writing 0xCCCC to the key address starts the watchdog. Before that, ticks have no effect and no request occurs. After the start, no key value stops it.
- R7: Counting from a refresh, the reset request follows the tick numbered divisor × reload. A reload of 0 behaves like a reload of 1.
- R8: The reset request is high for exactly one cycle, the cycle after the expiring tick. The counter then reloads, so timeouts repeat with the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Slow-clock tick enable, one cycle per slow period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 key, 1 prescaler, 2 reload, 3 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address; the key address reads 0 |
| rd_data | output | 16 | Read data for rd_addr |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The bench goes after the lock rules. A relock on refresh that never happens would let a later reload write through, and a locked write that still raises the busy flag would show up in the status read. It also checks that a second write during the busy window is dropped, and that each prescaler code, including both codes that alias to 256, gives a timeout of exactly divisor × reload ticks; an off-by-one in the phase or the counter would move the pulse one period early or late. A watchdog that stops on a non-start key, fires before being started, drives a request wider than one cycle, or fails to reload after expiring would lose the repeated-timeout and stop-attempt checks.

// File: rtl/kwdt_pkg.sv
// Shared constants for the key-protected watchdog: widths, register
// addresses, key values and the prescaler divisor decode.
package kwdt_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 2;
    localparam int CNT_W     = 12;
    localparam int PR_W      = 3;
    localparam int MAX_SHIFT = 6;              // largest divisor is 4 << MAX_SHIFT
    localparam int PS_W      = 2 + MAX_SHIFT;  // width of the prescaler phase

    localparam logic [ADDR_W-1:0] A_KEY = 2'd0;
    localparam logic [ADDR_W-1:0] A_PRE = 2'd1;
    localparam logic [ADDR_W-1:0] A_RLD = 2'd2;
    localparam logic [ADDR_W-1:0] A_STS = 2'd3;

    localparam logic [DATA_W-1:0] K_UNLOCK = 16'h5555;
    localparam logic [DATA_W-1:0] K_FEED   = 16'hAAAA;
    localparam logic [DATA_W-1:0] K_START  = 16'hCCCC;

    // Last phase value of one prescaled period for a code; codes above
    // MAX_SHIFT saturate at the largest divisor.
    function automatic logic [PS_W-1:0] div_last(input logic [PR_W-1:0] code);
        int sh;
        sh = (int'(code) > MAX_SHIFT) ? MAX_SHIFT : int'(code);
        return PS_W'((4 << sh) - 1);
    endfunction
endpackage

// File: rtl/kwdt_keygate.sv
// Key decoder. Turns writes to the key address into a held unlock state
// and single-cycle refresh and start strobes.
// Assumes the write port is sampled on every clock with wr_en qualifying it.
module kwdt_keygate
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              unlocked,
    output logic              feed,
    output logic              start
);
    logic key_wr;

    // Qualify a key access and decode the action keys.
    always_comb begin
        key_wr = wr_en && (wr_addr == A_KEY);
        feed   = key_wr && (wr_data == K_FEED);
        start  = key_wr && (wr_data == K_START);
    end

    // Unlock holds until the next key write that is not the unlock key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            unlocked <= 1'b0;
        else if (key_wr)
            unlocked <= (wr_data == K_UNLOCK);
    end

    // R2: any other key value locks the configuration again
    p_relock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data != K_UNLOCK) |=> !unlocked);

    // R2: the unlock key opens the configuration
    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data == K_UNLOCK) |=> unlocked);
endmodule

// File: rtl/kwdt_cfg_slot.sv
// One configuration register with a pending copy and a busy flag.
// An accepted write is held as pending and the busy flag is raised; the
// next tick applies it and clears the flag. Writes while busy or while
// locked are dropped. Assumes tick is a one-cycle enable.
module kwdt_cfg_slot #(
    parameter int               W       = 12,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic         unlocked,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         busy
);
    logic [W-1:0] pend;

    // Apply the pending value on a tick, otherwise capture an allowed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= RST_VAL;
            pend  <= RST_VAL;
            busy  <= 1'b0;
        end else if (busy && tick) begin
            value <= pend;
            busy  <= 1'b0;
        end else if (!busy && wr && unlocked) begin
            pend <= wdata;
            busy <= 1'b1;
        end
    end

    // R3: the busy flag clears on the tick that follows it
    p_busy_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick) |=> !busy);

    // R3: the visible value moves only on a committing tick
    p_value_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && tick) |=> $stable(value));

    // R2: a locked write leaves the slot untouched
    p_locked_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr && !unlocked) |=> (!busy && $stable(value)));
endmodule

// File: rtl/kwdt_presc.sv
// Tick prescaler. Counts ticks while the watchdog runs and emits a
// decrement strobe on the last tick of each prescaled period. A refresh
// restarts the phase. Assumes the code changes only on a tick.
module kwdt_presc
    import kwdt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            run,
    input  logic            restart,
    input  logic [PR_W-1:0] code,
    output logic            dec
);
    logic [PS_W-1:0] phase;
    logic [PS_W-1:0] last;

    // Decode the period length and flag its final tick.
    always_comb begin
        last = div_last(code);
        dec  = run && tick && !restart && (phase >= last);
    end

    // Advance the phase on running ticks; wrap at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (restart)
            phase <= '0;
        else if (run && tick)
            phase <= (phase >= last) ? '0 : phase + 1'b1;
    end

    // R6: a stopped watchdog does not advance its prescaler
    p_stop_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase));

    // R5: a refresh restarts the prescaled period
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == '0));
endmodule

// File: rtl/kwdt_count.sv
// Down counter, running state and reset request. On each decrement
// strobe the counter steps down; the strobe that takes it to zero fires
// a one-cycle request and reloads it. A refresh loads the reload value.
// Assumes decrement strobes are at least two cycles apart.
module kwdt_count
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec,
    input  logic             feed,
    input  logic             start,
    input  logic [CNT_W-1:0] reload,
    output logic             running,
    output logic             req
);
    logic [CNT_W-1:0] cnt;
    logic             expire;

    // The strobe that would leave zero (or starts from zero) is the expiry.
    always_comb expire = dec && !feed && (cnt <= CNT_W'(1));

    // Running is set by the start key and cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            running <= 1'b0;
        else if (start)
            running <= 1'b1;
    end

    // Refresh, step down, or reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= {CNT_W{1'b1}};
        else if (feed)
            cnt <= reload;
        else if (expire)
            cnt <= reload;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    // Register the one-cycle reset request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= 1'b0;
        else
            req <= expire;
    end

    // R6: once started the watchdog stays started
    p_run_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> running);

    // R6: no request while stopped
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !req);

    // R6: a stopped counter holds unless refreshed
    p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !feed) |=> $stable(cnt));

    // R8: the request lasts a single cycle
    p_pulse_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
endmodule

// File: rtl/kwdt_top.sv
// Key-protected watchdog top level. Wires the key decoder, the two
// configuration slots, the prescaler and the counter, and returns
// register contents on a combinational read port.
// Assumes a single clock domain with the slow clock given as tick.
module kwdt_top
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        rd_addr,
    output logic [15:0]       rd_data,
    output logic              rst_req
);
    localparam int NSLOT = 2;
    localparam int SW [NSLOT] = '{PR_W, CNT_W};
    localparam logic [ADDR_W-1:0] SA [NSLOT] = '{A_PRE, A_RLD};

    logic              unlocked, feed, start, dec, running;
    logic [PR_W-1:0]   pre_q;
    logic [CNT_W-1:0]  rld_q;
    logic [NSLOT-1:0]  busy;

    kwdt_keygate u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .unlocked (unlocked),
        .feed     (feed),
        .start    (start)
    );

    // One slot per configuration register; slot 0 prescaler, slot 1 reload.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        logic [SW[g]-1:0] val;
        logic             slot_wr;

        // Address decode for this slot.
        always_comb slot_wr = wr_en && (wr_addr == SA[g]);

        kwdt_cfg_slot #(
            .W       (SW[g]),
            .RST_VAL ((g == 0) ? {SW[g]{1'b0}} : {SW[g]{1'b1}})
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .wr       (slot_wr),
            .unlocked (unlocked),
            .wdata    (wr_data[SW[g]-1:0]),
            .value    (val),
            .busy     (busy[g])
        );
    end

    // Pick out the slot values with their own widths.
    always_comb begin
        pre_q = g_slot[0].val;
        rld_q = g_slot[1].val;
    end

    kwdt_presc u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (running),
        .restart (feed),
        .code    (pre_q),
        .dec     (dec)
    );

    kwdt_count u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .dec     (dec),
        .feed    (feed),
        .start   (start),
        .reload  (rld_q),
        .running (running),
        .req     (rst_req)
    );

    // Register read mux; the key address reads zero.
    always_comb begin
        case (rd_addr)
            A_PRE:   rd_data = DATA_W'(pre_q);
            A_RLD:   rd_data = DATA_W'(rld_q);
            A_STS:   rd_data = DATA_W'(busy);
            default: rd_data = '0;
        endcase
    end

    // R1: request low in the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !rst_req);
endmodule

// File: tb/kwdt_top_tb.sv
module kwdt_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    kwdt_top u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .rst_req(rst_req)
    );

    function automatic int bdiv(input int code);
        return (code >= 6) ? 256 : (4 << code);
    endfunction

    function automatic int btimeout(input int code, input int rl);
        return bdiv(code) * ((rl == 0) ? 1 : rl);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        rd_addr = a;
        #1 v = int'(rd_data);
    endtask

    // Issue n ticks; return how many request pulses were seen.
    task automatic ticks(input int n, output int pulses);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            if (rst_req) pulses++;
        end
    endtask

    // Count ticks until a request; -1 if none within lim. Checks width.
    task automatic measure(input int lim, output int n);
        bit found;
        found = 0; n = 0;
        while (!found && n < lim) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            n++;
            if (rst_req) found = 1;
        end
        if (!found) n = -1;
        @(negedge clk);
        check("R8 pulse width", int'(rst_req), 0);
    endtask

    initial begin
        int v, p, n, rl;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, v); check("R1 prescaler", v, 0);
        rd(2'd2, v); check("R1 reload", v, 4095);
        rd(2'd3, v); check("R1 status", v, 0);
        check("R1 request", int'(rst_req), 0);

        // R2 locked write ignored
        wr(2'd2, 16'd3);
        rd(2'd3, v); check("R2 locked status", v, 0);
        ticks(1, p);
        rd(2'd2, v); check("R2 locked reload", v, 4095);

        // R3 busy flags and commit on tick
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd2);
        rd(2'd3, v); check("R3 prescaler busy", v, 1);
        wr(2'd2, 16'd10);
        rd(2'd3, v); check("R3 both busy", v, 3);
        ticks(1, p);
        rd(2'd3, v); check("R3 busy cleared", v, 0);
        rd(2'd1, v); check("R3 prescaler value", v, 2);
        rd(2'd2, v); check("R3 reload value", v, 10);

        // R6 stopped watchdog never fires
        wr(2'd0, 16'hAAAA);
        ticks(300, p); check("R6 stopped no request", p, 0);

        // R6 R7 first timeout after start
        wr(2'd0, 16'hCCCC);
        measure(1000, n); check("R7 first timeout", n, btimeout(2, 10));
        // R8 repeated timeout
        measure(1000, n); check("R8 repeat timeout", n, btimeout(2, 10));

        // R5 regular refresh holds off the request
        p = 0;
        for (int i = 0; i < 8; i++) begin
            int q;
            wr(2'd0, 16'hAAAA);
            ticks(100 + (i % 50), q);
            p += q;
        end
        check("R5 refreshed no request", p, 0);

        // R6 stop attempts fail
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h1234);
        wr(2'd0, 16'hAAAA);
        measure(1000, n); check("R6 still running", n, btimeout(2, 10));

        // R2 refresh key relocks
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hAAAA);
        wr(2'd2, 16'd3);
        rd(2'd3, v); check("R2 relock status", v, 0);
        rd(2'd2, v); check("R2 relock reload", v, 10);

        // R3 write while busy dropped
        wr(2'd0, 16'h5555);
        wr(2'd2, 16'd5);
        wr(2'd2, 16'd7);
        ticks(1, p);
        rd(2'd2, v); check("R3 busy write dropped", v, 5);

        // R4 R7 every prescaler code with a random reload
        for (int c = 0; c < 8; c++) begin
            rl = 1 + int'($urandom % 12);
            wr(2'd0, 16'h5555);
            wr(2'd1, 16'(c));
            wr(2'd2, 16'(rl));
            ticks(1, p);
            rd(2'd1, v); check("R4 code readback", v, c);
            wr(2'd0, 16'hAAAA);
            measure(4000, n); check("R4 R7 timeout per code", n, btimeout(c, rl));
        end

        // R7 reload zero
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd0);
        ticks(1, p);
        wr(2'd0, 16'hAAAA);
        measure(100, n); check("R7 reload zero", n, btimeout(0, 0));

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R8 watchdog expired act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule